// File: doc/BRIEF.md
# Multi-Channel Endpoint DMA Engine

This block is a bus-master DMA engine for a USB function core. It has a set of independent channels. Each channel moves words between system memory and one endpoint FIFO. Software programs each channel through a small register port: a memory address, a byte count and a control word. The write of the control word with its enable bit set launches the channel.

When several channels are ready, a round-robin arbiter grants the memory port to one of them. The granted channel keeps the port for a whole burst. The burst length comes from the channel's control word and is cut short when fewer words remain. While data moves, each channel's address register advances and its count register falls. Software can therefore read back how many bytes were moved.

When a channel finishes, or the memory bus reports an error, the channel sets its bit in a shared completion byte. That byte clears when it is read. A single level interrupt output stays high while any bit of the byte is set.

Top module: `epdma_engine`

## Requirements
- R1: After reset every channel register and the completion byte read as zero, `irq` is low and `mem_req` is low.
- R2: Register map:
  - Channel c occupies byte offsets c*16 to c*16+15: the control word at +0, the address at +4 and the count at +8.
  - The completion byte is at offset 0x80.
  - Control bits: 0 enable, 1 direction (1 = memory to endpoint), 2 streaming mode, 3 interrupt enable, 7:4 endpoint, 8 bus error (read-only), 10:9 burst type.
  - The two low address bits are dropped when the address is written.
- R3: A control write with enable set starts the channel.
  - Each acknowledged beat adds the bytes moved (4, or the smaller remainder on the last beat) to the address and subtracts them from the count.
  - `mem_addr` always has its two low bits at zero.
  - Address minus start address equals the bytes moved.
- R4: Burst type 0 gives 1 beat per grant, 1 gives 4 beats, 2 gives 8 beats and 3 gives 16 beats. The length is cut to the words remaining. `mem_req` stays high for the whole burst, and the next burst starts only after at least one idle cycle.
- R5: When more than one channel is eligible, grants rotate round-robin among them.
- R6: Mode bit 0 serves one burst for each assertion of the endpoint request; the request must drop before the channel is served again. Mode bit 1 keeps issuing bursts for as long as the request stays high.
- R7: When the count reaches zero the channel clears its enable bit. It sets its completion bit only when its interrupt-enable bit is 1.
- R8: A read of offset 0x80 returns the pending bits and clears them. `irq` is high exactly while any bit is pending.
- R9: A beat with `mem_err` set ends the burst. That beat does not change the address or the count. The channel sets bit 8, clears enable, and sets its completion bit when interrupts are enabled.
- R10: Writing zero to the control word, then to the address and the count, returns a channel to idle. It is not served afterwards, even when its endpoint requests.
- R11: Direction 1 reads memory and presents `mem_rdata` on `ep_wdata` with `ep_ack`. Direction 0 writes `ep_rdata` to memory (`mem_we` = 1), with `ep_ack` on each good beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the completion byte at 0x80) |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Level interrupt, high while any completion bit is set |
| mem_req | output | 1 | Memory beat request, held for the whole burst |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | AW | Word-aligned beat address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Bus error on the acknowledged beat |
| ep_req | input | NEP | Per-endpoint service request |
| ep_sel | output | EPW | Endpoint of the active channel |
| ep_tx | output | 1 | 1 = push to the endpoint FIFO, 0 = pop from it |
| ep_ack | output | 1 | One FIFO word transferred this cycle |
| ep_wdata | output | DW | Data pushed to the endpoint FIFO |
| ep_rdata | input | DW | Data popped from the endpoint FIFO |

## Verification
A register write takes effect at the clock edge that samples it. The first clock edge after a channel becomes eligible performs the grant, and `mem_req` rises right after that edge. Each acknowledged beat updates the address and count at its own edge. The final beat's edge sets the completion bit and raises `irq`. Reads are combinational and clear the completion byte at the edge that samples them.

The bench drives every input and samples every output at the falling edge. It records each beat as the memory model accepts it. It reads registers back only after a settling window much longer than the transfer being checked, so each result is compared once it is final.

// File: rtl/epdma_engine.sv
module epdma_engine #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 20,
  parameter int NEP = 16,
  parameter int RAW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [RAW-1:0]         reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic                   irq,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  input  logic                   mem_ack,
  input  logic                   mem_err,
  input  logic [NEP-1:0]         ep_req,
  output logic [$clog2(NEP)-1:0] ep_sel,
  output logic                   ep_tx,
  output logic                   ep_ack,
  output logic [DW-1:0]          ep_wdata,
  input  logic [DW-1:0]          ep_rdata
);
  localparam int CHW  = $clog2(NCH);
  localparam int EPW  = $clog2(NEP);
  localparam int BPW  = DW / 8;
  localparam int OB   = $clog2(BPW);
  localparam int STAT = NCH * 16;

  logic [NCH-1:0] en, dir, md, ie, berr, armed, elig, stat, stat_set;
  logic [EPW-1:0] epn [NCH];
  logic [1:0]     bt  [NCH];
  logic [AW-1:0]  adr [NCH];
  logic [CW-1:0]  cnt [NCH];

  logic           busy, found, fin, rd_stat, wreg, ctrl_wr;
  logic [CHW-1:0] cur, rr, win, idx, rch;
  logic [1:0]     roff;
  logic [4:0]     left, beats, blen;
  logic [CW-1:0]  step, words;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = en[g] & armed[g] & ep_req[epn[g]] & (cnt[g] != '0);
  end

  always_comb begin
    found = 1'b0;
    win   = rr;
    idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      idx = rr + CHW'(k);
      if (!found && elig[idx]) begin
        found = 1'b1;
        win   = idx;
      end
    end
  end

  always_comb begin
    case (bt[win])
      2'd0:    blen = 5'd1;
      2'd1:    blen = 5'd4;
      2'd2:    blen = 5'd8;
      default: blen = 5'd16;
    endcase
  end

  assign words = (cnt[win] + CW'(BPW - 1)) >> OB;
  assign beats = (words < CW'(blen)) ? words[4:0] : blen;
  assign step  = (cnt[cur] < CW'(BPW)) ? cnt[cur] : CW'(BPW);

  assign fin      = busy & mem_ack & (mem_err | (cnt[cur] <= CW'(BPW)));
  assign stat_set = (fin && ie[cur]) ? (NCH'(1) << cur) : '0;

  assign rch     = reg_addr[CHW+3:4];
  assign roff    = reg_addr[3:2];
  assign rd_stat = reg_rd && (reg_addr == RAW'(STAT));
  assign wreg    = reg_wr && (reg_addr < RAW'(STAT)) && (reg_addr[1:0] == 2'b00);
  assign ctrl_wr = wreg && (roff == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; dir <= '0; md <= '0; ie <= '0; berr <= '0; armed <= '0; stat <= '0;
      for (int c = 0; c < NCH; c++) begin
        epn[c] <= '0; bt[c] <= '0; adr[c] <= '0; cnt[c] <= '0;
      end
      busy <= 1'b0; cur <= '0; rr <= '0; left <= '0;
    end else begin
      stat <= (stat & ~{NCH{rd_stat}}) | stat_set;
      for (int c = 0; c < NCH; c++)
        if (!ep_req[epn[c]]) armed[c] <= 1'b1;

      if (!busy) begin
        if (found && !(ctrl_wr && rch == win)) begin
          busy <= 1'b1;
          cur  <= win;
          rr   <= win;
          left <= beats;
        end
      end else if (mem_ack) begin
        if (mem_err) begin
          berr[cur] <= 1'b1;
          en[cur]   <= 1'b0;
          busy      <= 1'b0;
        end else begin
          adr[cur] <= adr[cur] + AW'(step);
          cnt[cur] <= cnt[cur] - step;
          left     <= left - 5'd1;
          if (cnt[cur] <= CW'(BPW)) begin
            en[cur] <= 1'b0;
            busy    <= 1'b0;
          end else if (left == 5'd1) begin
            busy       <= 1'b0;
            armed[cur] <= md[cur];
          end
        end
      end

      if (wreg) begin
        case (roff)
          2'd0: begin
            en[rch]    <= reg_wdata[0];
            dir[rch]   <= reg_wdata[1];
            md[rch]    <= reg_wdata[2];
            ie[rch]    <= reg_wdata[3];
            epn[rch]   <= reg_wdata[4 +: EPW];
            bt[rch]    <= reg_wdata[10:9];
            berr[rch]  <= 1'b0;
            armed[rch] <= 1'b1;
            if (busy && cur == rch) busy <= 1'b0;
          end
          2'd1:    adr[rch] <= AW'(reg_wdata) & ~AW'(BPW - 1);
          2'd2:    cnt[rch] <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(STAT))
      reg_rdata = DW'(stat);
    else if (reg_addr < RAW'(STAT) && reg_addr[1:0] == 2'b00) begin
      case (roff)
        2'd0:    reg_rdata = DW'({bt[rch], berr[rch], epn[rch], ie[rch], md[rch], dir[rch], en[rch]});
        2'd1:    reg_rdata = DW'(adr[rch]);
        2'd2:    reg_rdata = DW'(cnt[rch]);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq       = |stat;
  assign mem_req   = busy;
  assign mem_we    = ~dir[cur];
  assign mem_addr  = adr[cur] & ~AW'(BPW - 1);
  assign mem_wdata = ep_rdata;
  assign ep_sel    = epn[cur];
  assign ep_tx     = dir[cur];
  assign ep_ack    = busy & mem_ack & ~mem_err;
  assign ep_wdata  = mem_rdata;
endmodule

// File: rtl/epdma_engine_chk.sv
module epdma_engine_chk #(
  parameter int AW  = 32,
  parameter int NEP = 16,
  parameter int RAW = 8,
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_rd,
  input logic [RAW-1:0]         reg_addr,
  input logic                   irq,
  input logic                   mem_req,
  input logic                   mem_ack,
  input logic                   mem_err,
  input logic [AW-1:0]          mem_addr,
  input logic [NEP-1:0]         ep_req,
  input logic [$clog2(NEP)-1:0] ep_sel,
  input logic                   ep_ack
);
  localparam int BPW = DW / 8;
  logic [5:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n || !mem_req) run <= '0;
    else if (mem_ack) run <= run + 6'd1;
  end

  assert_beat_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_err) |=> (mem_req |-> mem_addr == $past(mem_addr) + AW'(BPW)));

  assert_burst_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |-> run < 6'd16);

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  assert_ack_requested_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ep_ack |-> ep_req[ep_sel]);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_rd && reg_addr == RAW'(NCH * 16)));

  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !mem_req);
endmodule

bind epdma_engine epdma_engine_chk #(.AW(AW), .NEP(NEP), .RAW(RAW), .NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
  .ep_req(ep_req), .ep_sel(ep_sel), .ep_ack(ep_ack)
);

// File: tb/epdma_engine_tb.sv
module epdma_engine_tb;
  localparam logic [31:0] MAGIC = 32'hA5A5_0000;
  localparam logic [31:0] RXD   = 32'hCAFE_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, ep_tx, ep_ack;
  logic [31:0] mem_addr, mem_wdata, ep_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] ep_req = '0;
  logic [3:0] ep_sel;
  logic [31:0] ep_rdata = RXD;

  logic err_on = 1'b0;
  logic [31:0] err_addr = '0;
  int checks = 0, errors = 0, cyc = 0;
  int log_n = 0, bn = 0, run = 0;
  logic [31:0] log_a [128];
  logic [31:0] log_d [128];
  logic [31:0] log_e [128];
  logic        log_w [128];
  logic        log_k [128];
  int          bl [64];

  always #10 clk = ~clk;

  epdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .ep_req(ep_req), .ep_sel(ep_sel), .ep_tx(ep_tx),
    .ep_ack(ep_ack), .ep_wdata(ep_wdata), .ep_rdata(ep_rdata)
  );

  always @(negedge clk) begin
    if (mem_req) begin
      mem_rdata = mem_addr ^ MAGIC;
      mem_err   = err_on && (mem_addr == err_addr);
      mem_ack   = 1'b1;
      #1;
      log_a[log_n] = mem_addr; log_w[log_n] = mem_we; log_d[log_n] = mem_wdata;
      log_e[log_n] = ep_wdata; log_k[log_n] = ep_ack;
      log_n++; run++;
    end else begin
      mem_ack = 1'b0; mem_err = 1'b0;
      if (run > 0) begin bl[bn] = run; bn++; run = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d cycles expected under 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [31:0] a, input logic [31:0] n, input logic [31:0] ctl);
    wr(8'(ch * 16 + 4), a);
    wr(8'(ch * 16 + 8), n);
    wr(8'(ch * 16), ctl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      rd(8'(c * 16), v);     check("R1", "ctrl after reset", v, 0);
      rd(8'(c * 16 + 4), v); check("R1", "addr after reset", v, 0);
      rd(8'(c * 16 + 8), v); check("R1", "count after reset", v, 0);
    end
    rd(8'h80, v); check("R1", "status after reset", v, 0);
    check("R1", "irq after reset", 32'(irq), 0);
    check("R1", "mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_tx_stream;
    logic [31:0] v;
    int b0 = log_n, k0 = bn;
    wr(8'h04, 32'h0000_1003);
    rd(8'h04, v); check("R2", "low address bits dropped", v, 32'h1000);
    wr(8'h08, 40);
    ep_req[2] = 1'b1;
    wr(8'h00, 32'h22F);
    wait_cyc(60);
    check("R3", "beat count", 32'(log_n - b0), 10);
    for (int i = 0; i < 10; i++) begin
      check("R3", "beat address", log_a[b0 + i], 32'h1000 + 32'(4 * i));
      check("R11", "tx is a memory read", 32'(log_w[b0 + i]), 0);
      check("R11", "tx data to endpoint", log_e[b0 + i], (32'h1000 + 32'(4 * i)) ^ MAGIC);
      check("R11", "tx ep_ack", 32'(log_k[b0 + i]), 1);
    end
    check("R4", "burst count", 32'(bn - k0), 3);
    check("R4", "burst 1 length", 32'(bl[k0]), 4);
    check("R4", "burst 2 length", 32'(bl[k0 + 1]), 4);
    check("R4", "shortened burst", 32'(bl[k0 + 2]), 2);
    rd(8'h04, v); check("R3", "final address", v, 32'h1028);
    rd(8'h08, v); check("R3", "final count", v, 0);
    rd(8'h00, v); check("R7", "enable cleared", v, 32'h22E);
    check("R8", "irq raised", 32'(irq), 1);
    rd(8'h80, v); check("R8", "status pending", v, 32'h01);
    rd(8'h80, v); check("R8", "status cleared by read", v, 0);
    check("R8", "irq dropped", 32'(irq), 0);
    ep_req[2] = 1'b0;
  endtask

  task automatic t_tail;
    logic [31:0] v;
    int b0 = log_n, k0 = bn;
    ep_req[3] = 1'b1;
    setup(1, 32'h2000, 10, 32'h63F);
    wait_cyc(30);
    check("R3", "tail beats", 32'(log_n - b0), 3);
    check("R4", "burst cut to remaining words", 32'(bl[k0]), 3);
    check("R3", "last beat aligned", log_a[b0 + 2], 32'h2008);
    rd(8'h14, v); check("R3", "address minus start equals bytes", v, 32'h200A);
    rd(8'h18, v); check("R3", "tail count", v, 0);
    rd(8'h80, v); check("R7", "ch1 complete", v, 32'h02);
    ep_req[3] = 1'b0;
  endtask

  task automatic t_round_robin;
    logic [31:0] v;
    int b0 = log_n;
    setup(1, 32'h3000, 8, 32'h04F);
    setup(2, 32'h4000, 8, 32'h05F);
    ep_req[4] = 1'b1; ep_req[5] = 1'b1;
    wait_cyc(30);
    check("R5", "total beats", 32'(log_n - b0), 4);
    check("R5", "grant alternates 0/1", 32'(log_a[b0][15:12] != log_a[b0 + 1][15:12]), 1);
    check("R5", "grant returns 0/2", 32'(log_a[b0][15:12] == log_a[b0 + 2][15:12]), 1);
    check("R5", "grant returns 1/3", 32'(log_a[b0 + 1][15:12] == log_a[b0 + 3][15:12]), 1);
    rd(8'h80, v); check("R5", "both complete", v, 32'h06);
    ep_req[4] = 1'b0; ep_req[5] = 1'b0;
  endtask

  task automatic t_mode0;
    logic [31:0] v;
    int b0 = log_n;
    ep_req[6] = 1'b1;
    setup(3, 32'h8000, 48, 32'h26B);
    wait_cyc(30);
    check("R6", "one burst per request", 32'(log_n - b0), 4);
    rd(8'h38, v); check("R6", "count after one burst", v, 32);
    ep_req[6] = 1'b0;
    wait_cyc(2);
    ep_req[6] = 1'b1;
    wait_cyc(30);
    check("R6", "second request served", 32'(log_n - b0), 8);
    rd(8'h38, v); check("R6", "count after two bursts", v, 16);
    ep_req[6] = 1'b0;
    wr(8'h30, 0);
  endtask

  task automatic t_bus_error;
    logic [31:0] v;
    int b0 = log_n;
    err_on = 1'b1; err_addr = 32'h5008;
    ep_req[7] = 1'b1;
    setup(4, 32'h5000, 32, 32'h47F);
    wait_cyc(30);
    check("R9", "stopped at error beat", 32'(log_n - b0), 3);
    check("R9", "no ep_ack on error beat", 32'(log_k[b0 + 2]), 0);
    rd(8'h40, v); check("R9", "error flag set, enable cleared", v, 32'h57E);
    rd(8'h48, v); check("R9", "count excludes error beat", v, 24);
    rd(8'h44, v); check("R9", "address at error beat", v, 32'h5008);
    rd(8'h80, v); check("R9", "error raises status", v, 32'h10);
    err_on = 1'b0; ep_req[7] = 1'b0;
  endtask

  task automatic t_no_ie;
    logic [31:0] v;
    int b0 = log_n;
    ep_req[8] = 1'b1;
    setup(5, 32'h9000, 8, 32'h087);
    wait_cyc(20);
    check("R7", "transfer ran", 32'(log_n - b0), 2);
    rd(8'h58, v); check("R7", "count reached zero", v, 0);
    check("R7", "irq stays low", 32'(irq), 0);
    rd(8'h80, v); check("R7", "no status bit", v, 0);
    ep_req[8] = 1'b0;
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int b0 = log_n;
    setup(6, 32'h6000, 16, 32'h09F);
    wr(8'h60, 0); wr(8'h64, 0); wr(8'h68, 0);
    ep_req[9] = 1'b1;
    wait_cyc(20);
    check("R10", "no beats after abort", 32'(log_n - b0), 0);
    check("R10", "mem_req idle", 32'(mem_req), 0);
    rd(8'h60, v); check("R10", "ctrl zero", v, 0);
    rd(8'h64, v); check("R10", "addr zero", v, 0);
    rd(8'h68, v); check("R10", "count zero", v, 0);
    ep_req[9] = 1'b0;
  endtask

  task automatic t_rx;
    logic [31:0] v;
    int b0 = log_n;
    ep_req[10] = 1'b1;
    setup(7, 32'h7000, 8, 32'h2AD);
    wait_cyc(20);
    check("R11", "rx beats", 32'(log_n - b0), 2);
    for (int i = 0; i < 2; i++) begin
      check("R11", "rx writes memory", 32'(log_w[b0 + i]), 1);
      check("R11", "rx data from endpoint", log_d[b0 + i], RXD);
      check("R11", "rx ep_ack", 32'(log_k[b0 + i]), 1);
      check("R11", "rx address", log_a[b0 + i], 32'h7000 + 32'(4 * i));
    end
    rd(8'h80, v); check("R8", "ch7 status", v, 32'h80);
    ep_req[10] = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_tx_stream();
    t_tail();
    t_round_robin();
    t_mode0();
    t_bus_error();
    t_no_ie();
    t_abort();
    t_rx();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule